// File: doc/BRIEF.md
# Byte-Lane Register Window Adapter

This adapter sits between a little-endian host register port and three banks of register targets that only accept whole 32-bit word writes. The host may issue 1-, 2- or 4-byte accesses at any byte offset inside a 128-byte window. The adapter decodes the offset into one of three regions: a bank of sixteen core words, a bank of eight DMA words, and a single bus-and-control word. Each target sees only word-wide read and write ports with one-cycle strobes.

An aligned full-word write passes straight through in one cycle. Any narrower or unaligned write is widened. In the first cycle the adapter samples the addressed word from the target without strobing it and merges the new bytes into their lanes. In the second cycle it issues a single write strobe carrying the merged word, and it holds the host ready signal low until then. A read completes in one cycle: the addressed word is shifted down by the byte offset and masked to the requested size. Unmapped offsets complete at once. Writes to them are dropped and reads return zero.

Top module: `regwin_adapter`

## Requirements
- R1: Offsets 0x00 to 0x3F select the core bank with word index host_addr[5:2], driven on `tgt_index`.
- R2: Offsets 0x40 to 0x5F select the DMA bank with word index (offset−0x40)>>2, i.e. host_addr[4:2].
- R3: Offsets 0x70 to 0x73 select the single bus-and-control word, with `tgt_index` = 0.
- R4: Every other offset is unmapped. The access completes in the same cycle with no strobe, and read data is 0.
- R5: `host_size` encodes bytes−1 (0 = 1 byte, 3 = 4 bytes). A 4-byte write at a word-aligned offset is one cycle long, and `tgt_wdata` equals `host_wdata`.
- R6: A write with fewer than 4 bytes, or at offset mod 4 ≠ 0, to a mapped region takes two cycles. `host_ready` is low in the first cycle, and the second cycle carries exactly one write strobe.
- R7: In a widened write, byte n of `host_wdata` lands in lane (offset mod 4)+n. Every other lane keeps the target word as it read in the first cycle, and the write goes to word offset with its two low bits cleared.
- R8: An access that would cross a word boundary is clipped to the lanes of the addressed word.
- R9: A read returns, in the same cycle, the word shifted right by 8×(offset mod 4) and masked to 8×bytes bits.
- R10: A read of a mapped offset asserts exactly one read strobe for one cycle. A write never asserts a read strobe.
- R11: After reset, with no request, `host_ready` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host request, held until ready |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 7 | Byte offset in the window |
| host_size | input | 2 | Access size minus one, in bytes |
| host_wdata | input | 32 | Write bytes, starting at lane 0 |
| host_ready | output | 1 | Access completes at this clock edge |
| host_rdata | output | 32 | Read bytes, shifted down to bit 0 |
| tgt_index | output | 4 | Word index inside the selected region |
| tgt_wdata | output | 32 | Full word to write |
| core_rd | output | 1 | Core bank read strobe |
| core_wr | output | 1 | Core bank write strobe |
| core_rdata | input | 32 | Core bank word at tgt_index |
| dma_rd | output | 1 | DMA bank read strobe |
| dma_wr | output | 1 | DMA bank write strobe |
| dma_rdata | input | 32 | DMA bank word at tgt_index |
| ctl_rd | output | 1 | Control word read strobe |
| ctl_wr | output | 1 | Control word write strobe |
| ctl_rdata | input | 32 | Control word |

## Verification
The hardest case to reach is a widened write in which the preserved lanes must come from the target word sampled one cycle earlier, while the clipping at offset 3 leaves only a single new lane. The stimulus preloads every target with a word whose bytes are all distinct. It then issues a 4-byte write at offset 3 and 1- and 2-byte writes at interior offsets, and compares the full stored word, byte by byte, with the value worked out from the lane rules. Strobe counters taken over each access confirm that no read strobe leaks into a widened write.

// File: rtl/regwin_adapter.sv
module regwin_adapter #(
  parameter int DW = 32,
  parameter int AW = 7,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_valid,
  input  logic          host_write,
  input  logic [AW-1:0] host_addr,
  input  logic [1:0]    host_size,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ready,
  output logic [DW-1:0] host_rdata,
  output logic [IW-1:0] tgt_index,
  output logic [DW-1:0] tgt_wdata,
  output logic          core_rd,
  output logic          core_wr,
  input  logic [DW-1:0] core_rdata,
  output logic          dma_rd,
  output logic          dma_wr,
  input  logic [DW-1:0] dma_rdata,
  output logic          ctl_rd,
  output logic          ctl_wr,
  input  logic [DW-1:0] ctl_rdata
);
  localparam int NB = DW / 8;
  localparam int OW = $clog2(NB);

  typedef enum logic [1:0] {RG_NONE, RG_CORE, RG_DMA, RG_CTL} region_e;

  logic [OW-1:0] off;
  logic [OW:0]   last_lane;
  logic [NB-1:0] lane_en;
  logic [DW-1:0] lane_mask, rd_mask;
  logic          is_core, is_dma, is_ctl, mapped;
  region_e       rgn;
  logic [IW-1:0] live_idx;
  logic [DW-1:0] cur_word, wr_lanes, merged, rd_shift;
  logic          full, idle_req, rmw_start, direct_wr, live_rd;

  logic          busy;
  logic [DW-1:0] hold_word;
  logic [IW-1:0] hold_idx;
  region_e       hold_rgn;

  assign off       = host_addr[OW-1:0];
  assign last_lane = {1'b0, off} + {1'b0, host_size};

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign lane_en[k]          = ((OW+1)'(k) >= {1'b0, off}) && ((OW+1)'(k) <= last_lane);
    assign lane_mask[8*k +: 8] = {8{lane_en[k]}};
    assign rd_mask[8*k +: 8]   = {8{2'(k) <= host_size}};
  end

  assign is_core = (host_addr[6] == 1'b0);
  assign is_dma  = (host_addr[6:5] == 2'b10);
  assign is_ctl  = (host_addr[6:2] == 5'b11100);
  assign mapped  = is_core || is_dma || is_ctl;

  always_comb begin
    rgn      = RG_NONE;
    live_idx = '0;
    cur_word = '0;
    if (is_core) begin
      rgn      = RG_CORE;
      live_idx = host_addr[5:2];
      cur_word = core_rdata;
    end else if (is_dma) begin
      rgn      = RG_DMA;
      live_idx = {1'b0, host_addr[4:2]};
      cur_word = dma_rdata;
    end else if (is_ctl) begin
      rgn      = RG_CTL;
      cur_word = ctl_rdata;
    end
  end

  assign wr_lanes = host_wdata << {off, 3'b000};
  assign merged   = (wr_lanes & lane_mask) | (cur_word & ~lane_mask);
  assign rd_shift = cur_word >> {off, 3'b000};

  assign full      = (host_size == 2'd3) && (off == '0);
  assign idle_req  = host_valid && !busy;
  assign rmw_start = idle_req && host_write && mapped && !full;
  assign direct_wr = idle_req && host_write && full;
  assign live_rd   = idle_req && !host_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      hold_word <= '0;
      hold_idx  <= '0;
      hold_rgn  <= RG_NONE;
    end else begin
      busy <= rmw_start;
      if (rmw_start) begin
        hold_word <= merged;
        hold_idx  <= live_idx;
        hold_rgn  <= rgn;
      end
    end
  end

  assign tgt_index = busy ? hold_idx : live_idx;
  assign tgt_wdata = busy ? hold_word : host_wdata;

  assign core_wr = (direct_wr && is_core) || (busy && hold_rgn == RG_CORE);
  assign dma_wr  = (direct_wr && is_dma)  || (busy && hold_rgn == RG_DMA);
  assign ctl_wr  = (direct_wr && is_ctl)  || (busy && hold_rgn == RG_CTL);
  assign core_rd = live_rd && is_core;
  assign dma_rd  = live_rd && is_dma;
  assign ctl_rd  = live_rd && is_ctl;

  assign host_ready = busy || (idle_req && !rmw_start);
  assign host_rdata = (live_rd && mapped) ? (rd_shift & rd_mask) : '0;

  // R6: at most one target written per cycle
  assert_one_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_wr, dma_wr, ctl_wr}));

  // R6: widened write stalls, then writes once
  assert_rmw_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_start |-> !host_ready);
  assert_rmw_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_start |=> host_ready && (core_wr || dma_wr || ctl_wr));

  // R7: lanes outside the new bytes keep the sampled target word
  assert_keep_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_start |=> ((tgt_wdata & ~$past(lane_mask)) == ($past(cur_word) & ~$past(lane_mask))));

  // R10: a read strobe finishes the access in that cycle
  assert_read_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd || dma_rd || ctl_rd) |-> host_ready && !host_write);

  // R4: unmapped accesses touch no target
  assert_unmapped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && !mapped) |-> host_ready && host_rdata == '0 &&
      !(core_rd || dma_rd || ctl_rd || core_wr || dma_wr || ctl_wr));

  // R11: nothing happens without a request
  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_valid && !busy) |-> !host_ready && !(core_wr || dma_wr || ctl_wr));
endmodule

// File: tb/regwin_adapter_tb.sv
module regwin_adapter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready;
  logic [31:0] host_rdata;
  logic [3:0]  tgt_index;
  logic [31:0] tgt_wdata;
  logic        core_rd, core_wr, dma_rd, dma_wr, ctl_rd, ctl_wr;
  logic [31:0] core_rdata, dma_rdata, ctl_rdata;

  logic [31:0] core_m [16];
  logic [31:0] dma_m  [8];
  logic [31:0] ctl_m;
  int rd_cnt, wr_cnt, checks, errors;
  bit done;

  always #2 clk = ~clk;

  regwin_adapter u_dut (.*);

  assign core_rdata = core_m[tgt_index];
  assign dma_rdata  = dma_m[tgt_index[2:0]];
  assign ctl_rdata  = ctl_m;

  always @(posedge clk) begin
    if (core_wr) core_m[tgt_index] <= tgt_wdata;
    if (dma_wr)  dma_m[tgt_index[2:0]] <= tgt_wdata;
    if (ctl_wr)  ctl_m <= tgt_wdata;
    rd_cnt <= rd_cnt + int'(core_rd) + int'(dma_rd) + int'(ctl_rd);
    wr_cnt <= wr_cnt + int'(core_wr) + int'(dma_wr) + int'(ctl_wr);
  end

  typedef struct packed {
    logic        w;
    logic [6:0]  a;
    logic [1:0]  s;
    logic [31:0] d;
    logic [31:0] e;
    logic [1:0]  c;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 7'h00, 2'd3, 32'h0,        32'h44332211, 2'd1},
    '{1'b0, 7'h05, 2'd0, 32'h0,        32'h00000022, 2'd1},
    '{1'b0, 7'h0A, 2'd1, 32'h0,        32'h00004433, 2'd1},
    '{1'b0, 7'h43, 2'd3, 32'h0,        32'h00000088, 2'd1},
    '{1'b0, 7'h71, 2'd1, 32'h0,        32'h0000BBAA, 2'd1},
    '{1'b0, 7'h60, 2'd3, 32'h0,        32'h00000000, 2'd1},
    '{1'b1, 7'h0C, 2'd3, 32'hDEADBEEF, 32'hDEADBEEF, 2'd1},
    '{1'b1, 7'h11, 2'd0, 32'h000000EE, 32'h4433EE11, 2'd2},
    '{1'b1, 7'h46, 2'd1, 32'h0000CAFE, 32'hCAFE6655, 2'd2},
    '{1'b1, 7'h5F, 2'd3, 32'h12345678, 32'h78776655, 2'd2},
    '{1'b1, 7'h72, 2'd0, 32'h0000005A, 32'hCC5AAA99, 2'd2},
    '{1'b1, 7'h7C, 2'd3, 32'hFFFFFFFF, 32'h00000000, 2'd1}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R9 R1";
      1: return "R9";
      2: return "R9";
      3: return "R8 R2";
      4: return "R3 R9";
      5: return "R4";
      6: return "R5";
      7: return "R7 R6";
      8: return "R7 R2";
      9: return "R8 R7";
      10: return "R3 R6";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [31:0] peek(logic [6:0] a);
    if (a < 7'h40) return core_m[a[5:2]];
    if (a < 7'h60) return dma_m[a[4:2]];
    if (a[6:2] == 5'b11100) return ctl_m;
    return 32'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_acc(input logic w, input logic [6:0] a, input logic [1:0] s,
                        input logic [31:0] d, output logic [31:0] rd, output int cyc);
    logic got;
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    host_valid = 1'b1; host_write = w; host_addr = a; host_size = s; host_wdata = d;
    cyc = 0;
    do begin
      #1;
      cyc++;
      got = host_ready;
      rd = host_rdata;
      @(negedge clk);
    end while (!got && cyc < 8);
    host_valid = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int cyc;
    for (int i = 0; i < 16; i++) core_m[i] = 32'h44332211;
    for (int i = 0; i < 8; i++) dma_m[i] = 32'h88776655;
    ctl_m = 32'hCCBBAA99;
    rd_cnt = 0; wr_cnt = 0; checks = 0; errors = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R11 ready", 32'(host_ready), 32'h0);
    chk("R11 strobes", 32'({core_rd, core_wr, dma_rd, dma_wr, ctl_rd, ctl_wr}), 32'h0);

    for (int i = 0; i < 12; i++) begin
      vec_t v;
      v = VEC[i];
      do_acc(v.w, v.a, v.s, v.d, rd, cyc);
      if (v.w) chk(vec_tag(i), peek(v.a), v.e);
      else     chk(vec_tag(i), rd, v.e);
      chk({vec_tag(i), " cycles"}, 32'(cyc), 32'(v.c));
      if (v.w) begin
        chk("R10 write has no read strobe", 32'(rd_cnt), 32'h0);
        chk("R6 write strobe count", 32'(wr_cnt), (peek(v.a) === 32'h0 && v.a >= 7'h60) ? 32'h0 : 32'h1);
      end else begin
        chk("R10 read strobe count", 32'(rd_cnt), (v.a >= 7'h60 && v.a[6:2] != 5'b11100) ? 32'h0 : 32'h1);
        chk("R10 read has no write strobe", 32'(wr_cnt), 32'h0);
      end
    end

    chk("R4 dropped write left control word", ctl_m, 32'hCC5AAA99);
    do_acc(1'b0, 7'h7C, 2'd3, 32'h0, rd, cyc);
    chk("R4 unmapped read", rd, 32'h0);
    chk("R2 decode kept core word 7", core_m[7], 32'h44332211);
    chk("R1 index 4 written only", core_m[5], 32'h44332211);
    do_acc(1'b1, 7'h70, 2'd3, 32'h0BADF00D, rd, cyc);
    chk("R3 R5 aligned control write", ctl_m, 32'h0BADF00D);
    chk("R5 aligned write one cycle", 32'(cyc), 32'h1);
    do_acc(1'b1, 7'h3F, 2'd1, 32'h0000A1B2, rd, cyc);
    chk("R8 R1 clipped core write", core_m[15], 32'hB2332211);
    do_acc(1'b0, 7'h3E, 2'd1, 32'h0, rd, cyc);
    chk("R9 halfword read upper lanes", rd, 32'h0000B233);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule